// File: doc/BRIEF.md
# Companion I/O controller with register-mapped GPIO bank

This block is a small peripheral that answers a simple synchronous bus: an address, a write strobe, a read strobe, write data and registered read data. It holds a set of 16-bit card-side registers for mode, detect, card control, power, interrupt request, interrupt mask and interrupt status, plus one read-only card status word. The power register has one side effect: a write with its trigger bit set also forces two more bits high.

It also owns a bank of sixteen general-purpose pins. Each pin has a direction bit and a level bit. Software writes the levels through either of two aliased offsets, and each write is masked by the direction word. External input lines can set or clear individual level bits. The pin outputs show the level of every pin that is configured as an output. They are refreshed only when software writes the level or direction word. A one-cycle pulse vector marks every output bit that toggled on that refresh.

Top module: `compio_ctrl`

## Requirements
- R1: After reset every register reads 0x0000, except the card status word (offset 0x08), which reads 0x0002. `pin_out` and `pin_changed` are 0.
- R2: A write to mode (0x00), detect (0x04), card control (0x10), interrupt request (0x14), interrupt mask (0x18) or interrupt status (0x1C) stores bits [15:0] of the write data. A read at the same offset returns that value.
- R3: A write to the power register (0x0C) stores bits [15:0] of the write data. If bit 7 of the written value is 1, the stored value is also ORed with 0x8040.
- R4: Writes to the card status offset (0x08) are ignored. It always reads 0x0002.
- R5: Only address bits [5:0] are decoded. An address that differs only in higher bits reaches the same register.
- R6: Offsets not listed in R2–R4, R7 or R8 read 0x0000. Writes to them change no register.
- R7: A write to offset 0x24 or 0x28 stores (write data AND direction) as the pin level word. A read at either offset returns the pin level word.
- R8: A write to offset 0x20 stores the direction word and leaves the level word unchanged. A read at 0x20 returns the direction word.
- R9: Each write to the level or direction word makes `pin_out` equal to (level AND direction), both taken after the write, at the clock edge of the write. `pin_changed` is high for exactly the next cycle, on each bit that toggled.
- R10: When `pin_set_en[i]` is high, bit i of the level word takes `pin_set_val[i]`. This does not change `pin_out`.
- R11: A bus write to the level word in the same cycle as an input-line update wins on every bit.
- R12: `rd_data` is updated on the clock edge that samples `bus_re`. It holds its value while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address; only bits [5:0] are decoded |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | WDATA_W (32) | Write data; bits [15:0] are used |
| rd_data | output | 16 | Registered read data |
| pin_set_en | input | 16 | Per-line update strobe from external inputs |
| pin_set_val | input | 16 | Per-line level from external inputs |
| pin_out | output | 16 | Output pin levels (level AND direction) |
| pin_changed | output | 16 | One-cycle pulse on each output bit that toggled |

## Verification
The bench uses the default widths: a 12-bit address and 32-bit write data. This lets it write upper-half data bits that must be dropped, and reach addresses such as 0x040 and 0x080 that alias low offsets through the undecoded bits.

With sixteen pins, the bench covers direction masks that split the bank into halves and nibbles. This shows partial toggles, pins masked off by direction, external updates on the top and bottom pins, and a bus write colliding with an input update.

// File: rtl/compio_pkg.sv
package compio_pkg;

    localparam int DATA_W  = 16;
    localparam int DEC_W   = 6;

    localparam logic [DATA_W-1:0] STATUS_RESET = 16'h0002;
    localparam int                PWR_TRIG_BIT = 7;
    localparam logic [DATA_W-1:0] PWR_FORCE    = 16'h8040;

    typedef enum logic [3:0] {
        RS_MODE,
        RS_DETECT,
        RS_STATUS,
        RS_POWER,
        RS_CARDCTL,
        RS_IRQREQ,
        RS_IMASK,
        RS_ISTAT,
        RS_DIR,
        RS_LVL,
        RS_NONE
    } regsel_e;

    typedef struct packed {
        logic              we;
        logic              re;
        regsel_e           sel;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] detect;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] power;
        logic [DATA_W-1:0] cardctl;
        logic [DATA_W-1:0] irqreq;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] istat;
    } ctl_regs_t;

    function automatic regsel_e decode_offset(input logic [DEC_W-1:0] off);
        regsel_e s;
        case (off)
            6'h00:        s = RS_MODE;
            6'h04:        s = RS_DETECT;
            6'h08:        s = RS_STATUS;
            6'h0C:        s = RS_POWER;
            6'h10:        s = RS_CARDCTL;
            6'h14:        s = RS_IRQREQ;
            6'h18:        s = RS_IMASK;
            6'h1C:        s = RS_ISTAT;
            6'h20:        s = RS_DIR;
            6'h24, 6'h28: s = RS_LVL;
            default:      s = RS_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] power_value(input logic [DATA_W-1:0] w);
        return w[PWR_TRIG_BIT] ? (w | PWR_FORCE) : w;
    endfunction

endpackage

// File: rtl/compio_decode.sv
module compio_decode
    import compio_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WDATA_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic               re,
    input  logic [WDATA_W-1:0] wdata,
    output bus_op_t            op
);
    always_comb begin
        op.we   = we;
        op.re   = re;
        op.sel  = decode_offset(addr[DEC_W-1:0]);
        op.data = wdata[DATA_W-1:0];
    end
endmodule

// File: rtl/compio_ctlregs.sv
module compio_ctlregs
    import compio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_op_t   op,
    output ctl_regs_t regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs        <= '0;
            regs.status <= STATUS_RESET;
        end else if (op.we) begin
            case (op.sel)
                RS_MODE:    regs.mode    <= op.data;
                RS_DETECT:  regs.detect  <= op.data;
                RS_POWER:   regs.power   <= power_value(op.data);
                RS_CARDCTL: regs.cardctl <= op.data;
                RS_IRQREQ:  regs.irqreq  <= op.data;
                RS_IMASK:   regs.imask   <= op.data;
                RS_ISTAT:   regs.istat   <= op.data;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/compio_pinbank.sv
module compio_pinbank #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl_we,
    input  logic              dir_we,
    input  logic [N_PINS-1:0] wdata,
    input  logic [N_PINS-1:0] ext_en,
    input  logic [N_PINS-1:0] ext_val,
    output logic [N_PINS-1:0] level_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] out_q,
    output logic [N_PINS-1:0] chg_q
);
    logic              refresh;
    logic [N_PINS-1:0] dir_next;

    assign refresh  = lvl_we | dir_we;
    assign dir_next = dir_we ? wdata : dir_q;

    always_ff @(posedge clk) begin
        if (rst) dir_q <= '0;
        else     dir_q <= dir_next;
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic lvl_next;
        logic eff;

        always_comb begin
            if (lvl_we)         lvl_next = wdata[i] & dir_q[i];
            else if (ext_en[i]) lvl_next = ext_val[i];
            else                lvl_next = level_q[i];
            eff = lvl_next & dir_next[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                level_q[i] <= 1'b0;
                out_q[i]   <= 1'b0;
                chg_q[i]   <= 1'b0;
            end else begin
                level_q[i] <= lvl_next;
                chg_q[i]   <= refresh & (eff ^ out_q[i]);
                if (refresh) out_q[i] <= eff;
            end
        end
    end
endmodule

// File: rtl/compio_ctrl.sv
module compio_ctrl
    import compio_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [WDATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [DATA_W-1:0]  pin_set_en,
    input  logic [DATA_W-1:0]  pin_set_val,
    output logic [DATA_W-1:0]  pin_out,
    output logic [DATA_W-1:0]  pin_changed
);
    bus_op_t           op;
    ctl_regs_t         regs;
    logic [DATA_W-1:0] level_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] rd_next;

    compio_decode #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .re   (bus_re),
        .wdata(bus_wdata),
        .op   (op)
    );

    compio_ctlregs u_regs (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .regs(regs)
    );

    compio_pinbank #(.N_PINS(DATA_W)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .lvl_we (op.we && op.sel == RS_LVL),
        .dir_we (op.we && op.sel == RS_DIR),
        .wdata  (op.data),
        .ext_en (pin_set_en),
        .ext_val(pin_set_val),
        .level_q(level_q),
        .dir_q  (dir_q),
        .out_q  (pin_out),
        .chg_q  (pin_changed)
    );

    always_comb begin
        case (op.sel)
            RS_MODE:    rd_next = regs.mode;
            RS_DETECT:  rd_next = regs.detect;
            RS_STATUS:  rd_next = regs.status;
            RS_POWER:   rd_next = regs.power;
            RS_CARDCTL: rd_next = regs.cardctl;
            RS_IRQREQ:  rd_next = regs.irqreq;
            RS_IMASK:   rd_next = regs.imask;
            RS_ISTAT:   rd_next = regs.istat;
            RS_DIR:     rd_next = dir_q;
            RS_LVL:     rd_next = level_q;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (op.re)  rd_data <= rd_next;
    end
endmodule

// File: rtl/compio_ctrl_chk.sv
module compio_ctrl_chk
    import compio_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WDATA_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic               bus_re,
    input logic [WDATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0]  rd_data,
    input logic [DATA_W-1:0]  pin_set_en,
    input logic [DATA_W-1:0]  pin_set_val,
    input logic [DATA_W-1:0]  pin_out,
    input logic [DATA_W-1:0]  pin_changed
);
    regsel_e sel;
    assign sel = decode_offset(bus_addr[DEC_W-1:0]);

    a_r9_pulse_marks_toggle: assert property (@(posedge clk) disable iff (rst)
        (pin_changed != '0) |-> (pin_changed == (pin_out ^ $past(pin_out))));

    a_r10_outputs_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_out) && pin_changed == '0));

    a_r4_status_constant: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel == RS_STATUS) |=> (rd_data == STATUS_RESET));

    a_r6_undefined_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel == RS_NONE) |=> (rd_data == '0));

    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(rd_data));
endmodule

bind compio_ctrl compio_ctrl_chk #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W)) u_chk (.*);

// File: tb/tb_compio_ctrl.sv
module tb_compio_ctrl;
    localparam int ADDR_W  = 12;
    localparam int WDATA_W = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_we = 1'b0;
    logic               bus_re = 1'b0;
    logic [WDATA_W-1:0] bus_wdata = '0;
    logic [15:0]        rd_data;
    logic [15:0]        pin_set_en = '0;
    logic [15:0]        pin_set_val = '0;
    logic [15:0]        pin_out;
    logic [15:0]        pin_changed;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    compio_ctrl #(.ADDR_W(ADDR_W), .WDATA_W(WDATA_W)) dut (.*);

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h1234_ABCD, 16'h0000, 8'd2},  // R2 mode, upper half dropped
        '{1'b0, 12'h000, 32'h0,         16'hABCD, 8'd2},
        '{1'b1, 12'h004, 32'h0000_5555, 16'h0000, 8'd2},  // R2 detect
        '{1'b0, 12'h004, 32'h0,         16'h5555, 8'd2},
        '{1'b1, 12'h010, 32'hFFFF_0F0F, 16'h0000, 8'd2},  // R2 card control
        '{1'b0, 12'h010, 32'h0,         16'h0F0F, 8'd2},
        '{1'b1, 12'h014, 32'h0000_1111, 16'h0000, 8'd2},  // R2 irq request
        '{1'b0, 12'h014, 32'h0,         16'h1111, 8'd2},
        '{1'b1, 12'h018, 32'h0000_2222, 16'h0000, 8'd2},  // R2 irq mask
        '{1'b0, 12'h018, 32'h0,         16'h2222, 8'd2},
        '{1'b1, 12'h01C, 32'h0000_3333, 16'h0000, 8'd2},  // R2 irq status
        '{1'b0, 12'h01C, 32'h0,         16'h3333, 8'd2},
        '{1'b1, 12'h00C, 32'h0000_0080, 16'h0000, 8'd3},  // R3 trigger bit alone
        '{1'b0, 12'h00C, 32'h0,         16'h80C0, 8'd3},
        '{1'b1, 12'h00C, 32'h0000_0001, 16'h0000, 8'd3},  // R3 no trigger
        '{1'b0, 12'h00C, 32'h0,         16'h0001, 8'd3},
        '{1'b1, 12'h00C, 32'hFFFF_21A5, 16'h0000, 8'd3},  // R3 trigger with others
        '{1'b0, 12'h00C, 32'h0,         16'hA1E5, 8'd3},
        '{1'b1, 12'h008, 32'h0000_FFFF, 16'h0000, 8'd4},  // R4 status write ignored
        '{1'b0, 12'h008, 32'h0,         16'h0002, 8'd4},
        '{1'b1, 12'h040, 32'h0000_7777, 16'h0000, 8'd5},  // R5 alias of mode
        '{1'b0, 12'h000, 32'h0,         16'h7777, 8'd5},
        '{1'b0, 12'h080, 32'h0,         16'h7777, 8'd5},
        '{1'b1, 12'h002, 32'h0000_BEEF, 16'h0000, 8'd6},  // R6 undefined offsets
        '{1'b1, 12'h02C, 32'h0000_9999, 16'h0000, 8'd6},
        '{1'b0, 12'h02C, 32'h0,         16'h0000, 8'd6},
        '{1'b0, 12'h03C, 32'h0,         16'h0000, 8'd6},
        '{1'b0, 12'h000, 32'h0,         16'h7777, 8'd6}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 pin_out", pin_out, 16'h0000);
        check("R1 pin_changed", pin_changed, 16'h0000);
        for (int a = 0; a < 12'h2C; a += 4) begin
            rd(a[11:0], v);
            check("R1 reset read", v, (a == 8) ? 16'h0002 : 16'h0000);
        end

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                check($sformatf("R%0d table entry %0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R8 direction write, level stays zero
        wr(12'h020, 32'hABCD_00FF);
        check("R8 pin_out after dir", pin_out, 16'h0000);
        check("R9 no toggle", pin_changed, 16'h0000);
        rd(12'h020, v); check("R8 dir readback", v, 16'h00FF);

        // R7 level write masked by direction
        wr(12'h024, 32'h0000_FFFF);
        check("R9 pin_out", pin_out, 16'h00FF);
        check("R9 changed pulse", pin_changed, 16'h00FF);
        @(negedge clk);
        check("R9 pulse one cycle", pin_changed, 16'h0000);
        rd(12'h028, v); check("R7 level via alias read", v, 16'h00FF);

        // R8 new direction keeps level, refreshes outputs
        wr(12'h020, 32'h0000_0F0F);
        check("R8 pin_out", pin_out, 16'h000F);
        check("R9 changed", pin_changed, 16'h00F0);
        rd(12'h024, v); check("R8 level unchanged", v, 16'h00FF);

        // R7 alias write offset
        wr(12'h028, 32'h0000_0A0A);
        check("R7 alias write out", pin_out, 16'h0A0A);
        check("R9 changed", pin_changed, 16'h0A05);

        // R10 external lines update level only
        @(negedge clk);
        pin_set_en = 16'h8001; pin_set_val = 16'h8000;
        @(negedge clk);
        pin_set_en = '0; pin_set_val = '0;
        check("R10 pin_out held", pin_out, 16'h0A0A);
        check("R10 no pulse", pin_changed, 16'h0000);
        rd(12'h024, v); check("R10 level updated", v, 16'h8A0A);
        wr(12'h020, 32'h0000_8F0F);
        check("R10 level seen on refresh", pin_out, 16'h8A0A);
        check("R9 changed", pin_changed, 16'h8000);

        // R11 bus write beats same-cycle input update
        @(negedge clk);
        bus_addr = 12'h024; bus_wdata = 32'h0; bus_we = 1'b1;
        pin_set_en = 16'h0002; pin_set_val = 16'h0002;
        @(negedge clk);
        bus_we = 1'b0; pin_set_en = '0; pin_set_val = '0;
        check("R11 pin_out", pin_out, 16'h0000);
        check("R11 changed", pin_changed, 16'h8A0A);
        rd(12'h024, v); check("R11 level", v, 16'h0000);

        // R12 read data holds without read strobe
        rd(12'h018, v);
        @(negedge clk);
        bus_addr = 12'h01C;
        repeat (2) @(negedge clk);
        check("R12 hold", rd_data, 16'h2222);

        finish_run();
    end
endmodule